// File: doc/BRIEF.md
# CAN Operating-Mode Sequencer

This block is the top-level mode state machine of a CAN protocol controller. It decides whether the controller is asleep, waking the bus, resynchronising to bus traffic, idle, sending, receiving or handling an error. It does not code frames itself. It acts on a once-per-bit strobe from the bit-timing logic, on the sampled receive level (0 means dominant) and on single-cycle status pulses from the bit-level engine. Its outputs are the current mode, a dominant drive request for the wake-up pulse, a wake-up interrupt, a run read-back and the enable for the bit-timing and prescaler logic.

Software requests operation with a run level and puts the block to sleep by clearing that level. A frame that is already on the bus always completes before the block sleeps. The block does not sleep while the receive line is held dominant. On the way back to operation, the block can first drive one dominant bit to wake the other nodes. It then waits for a quiet bus. After a bus-off event it waits for a much longer quiet period before it returns to idle.

Top module: `can_mode_seq`

## Requirements
- R1: A synchronous active-high reset puts the block in standby. The mode codes are: standby 0, wake-up 1, resync 2, idle 3, transmit 4, receive 5, error 6. After reset, force_dom and wake_irq are low.
- R2: run_rb and bt_enable are 0 in standby and 1 in every other mode.
- R3: In standby, a bit strobe that samples rx_bit at 0 while wkirq_en is 1 raises wake_irq for exactly the following cycle. When wkirq_en is 0, no interrupt is raised.
- R4: In standby with run_en at 1, the block moves to wake-up if wkpulse_en is 1, and to resync if it is 0.
- R5: In wake-up, force_dom rises at the first bit strobe and stays high until the next bit strobe, which is exactly one bit time. At that second strobe the block moves to resync.
- R6: Resync moves to idle on the strobe that completes 11 consecutive recessive samples. A dominant sample restarts the count.
- R7: bus_off in idle, transmit, receive or error sends the block to resync. The next exit from resync then needs 128 runs of 11 recessive samples. A dominant sample restarts only the run in progress.
- R8: In idle, tx_req starts transmit and sof_pulse starts receive. tx_req wins when both arrive in the same cycle.
- R9: In transmit, arb_lost moves to receive and tx_ok returns to idle. In receive, rx_ok returns to idle.
- R10: tx_err in transmit and rx_err in receive move to error. In error, frame_sync leads back to transmit if the error was a transmit error with no_retx at 0 and run_en is 1. Otherwise frame_sync leads to idle.
- R11: Clearing run_en does not interrupt a frame in transmit, receive or error. Once the block is in idle or resync with run_en at 0 and rx_bit at 1, it enters standby.
- R12: While rx_bit is held at 0, clearing run_en does not cause an entry into standby.
- R13: In standby, wake-up and resync, frame status pulses (sof_pulse, rx_ok, rx_err, tx_ok, tx_err, arb_lost) and tx_req leave the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Sampled receive level, 0 = dominant |
| run_en | input | 1 | Software run request |
| wkpulse_en | input | 1 | Drive a wake-up pulse before resync |
| wkirq_en | input | 1 | Enable wake-up interrupt in standby |
| tx_req | input | 1 | Transmit request (last data byte written) |
| sof_pulse | input | 1 | Start of frame seen |
| rx_ok | input | 1 | Frame received correctly |
| rx_err | input | 1 | Receive error |
| tx_ok | input | 1 | Frame sent correctly |
| tx_err | input | 1 | Transmit error |
| no_retx | input | 1 | Do not retry after a transmit error |
| arb_lost | input | 1 | Arbitration lost |
| bus_off | input | 1 | Bus-off reached |
| frame_sync | input | 1 | Bit engine back in frame step after an error |
| mode_o | output | 3 | Current mode code (R1) |
| force_dom | output | 1 | Drive the bus dominant |
| wake_irq | output | 1 | Wake-up interrupt pulse |
| run_rb | output | 1 | Run read-back |
| bt_enable | output | 1 | Bit-timing and prescaler enable |

## Verification
The bench stretches the bit strobe to several clocks during wake-up. A sequencer that timed the pulse in clocks, or started it on entry, would show a force_dom width other than one bit time. It breaks a recessive run with a dominant sample, both in plain resync and during bus-off recovery. A counter that did not restart, or that lost completed runs, would leave resync at the wrong cycle. It clears run mid-frame and with the line held dominant, where a careless design would drop into standby too early. Error exits are tried both with and without retry, which catches a retry flag taken from the wrong source.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        MODE_STANDBY = 3'd0,
        MODE_WAKEUP  = 3'd1,
        MODE_RESYNC  = 3'd2,
        MODE_IDLE    = 3'd3,
        MODE_TX      = 3'd4,
        MODE_RX      = 3'd5,
        MODE_ERROR   = 3'd6
    } mode_e;

    typedef struct packed {
        logic sof;
        logic rx_ok;
        logic rx_err;
        logic tx_ok;
        logic tx_err;
        logic no_retx;
        logic arb_lost;
        logic bus_off;
        logic frame_sync;
    } engine_status_t;

    localparam int unsigned QUIET_BITS_DEF = 11;
    localparam int unsigned BOFF_RUNS_DEF  = 128;

    // modes in which the bit engine is live on the bus
    function automatic logic on_bus(mode_e m);
        return (m == MODE_IDLE) || (m == MODE_TX) ||
               (m == MODE_RX)   || (m == MODE_ERROR);
    endfunction

endpackage

// File: rtl/can_quiet_counter.sv
module can_quiet_counter
    import can_mode_pkg::*;
#(
    parameter int unsigned QUIET_BITS = QUIET_BITS_DEF,
    parameter int unsigned BOFF_RUNS  = BOFF_RUNS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    input  logic rx_bit,
    input  logic long_mode,
    output logic done
);
    localparam int unsigned BW = $clog2(QUIET_BITS + 1);
    localparam int unsigned GW = $clog2(BOFF_RUNS + 1);

    logic [BW-1:0] bit_cnt;
    logic [GW-1:0] run_cnt;
    logic          run_end;
    logic          last_run;

    assign run_end  = tick && rx_bit && (bit_cnt == BW'(QUIET_BITS - 1));
    assign last_run = !long_mode || (run_cnt == GW'(BOFF_RUNS - 1));
    assign done     = !clear && run_end && last_run;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bit_cnt <= '0;
            run_cnt <= '0;
        end else if (tick) begin
            if (!rx_bit) begin
                bit_cnt <= '0;
            end else if (run_end) begin
                bit_cnt <= '0;
                if (long_mode) run_cnt <= run_cnt + GW'(1);
            end else begin
                bit_cnt <= bit_cnt + BW'(1);
            end
        end
    end
endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl
    import can_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e mode,
    input  logic  tick,
    input  logic  rx_bit,
    input  logic  irq_en,
    output logic  pulse_on,
    output logic  force_dom,
    output logic  wake_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_on <= 1'b0;
            wake_irq <= 1'b0;
        end else begin
            if (mode != MODE_WAKEUP) pulse_on <= 1'b0;
            else if (tick)           pulse_on <= 1'b1;
            wake_irq <= (mode == MODE_STANDBY) && tick && !rx_bit && irq_en;
        end
    end

    assign force_dom = (mode == MODE_WAKEUP) && pulse_on;
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
    import can_mode_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           rx_bit,
    input  logic           run_en,
    input  logic           wkpulse_en,
    input  logic           tx_req,
    input  engine_status_t st,
    input  logic           quiet_done,
    input  logic           pulse_on,
    output mode_e          mode,
    output logic           boff_mode
);
    mode_e mode_nx;
    logic  retry_q, retry_nx;
    logic  boff_nx;

    always_comb begin
        mode_nx  = mode;
        retry_nx = retry_q;
        boff_nx  = boff_mode;
        if (on_bus(mode) && st.bus_off) begin
            mode_nx = MODE_RESYNC;
            boff_nx = 1'b1;
        end else begin
            unique case (mode)
                MODE_STANDBY:
                    if (run_en) mode_nx = wkpulse_en ? MODE_WAKEUP : MODE_RESYNC;
                MODE_WAKEUP:
                    if (pulse_on && tick) mode_nx = MODE_RESYNC;
                MODE_RESYNC:
                    if (!run_en && rx_bit) mode_nx = MODE_STANDBY;
                    else if (quiet_done) begin
                        mode_nx = MODE_IDLE;
                        boff_nx = 1'b0;
                    end
                MODE_IDLE:
                    if (!run_en) begin
                        if (rx_bit) mode_nx = MODE_STANDBY;
                    end else if (tx_req) mode_nx = MODE_TX;
                    else if (st.sof)     mode_nx = MODE_RX;
                MODE_TX:
                    if (st.arb_lost)    mode_nx = MODE_RX;
                    else if (st.tx_ok)  mode_nx = MODE_IDLE;
                    else if (st.tx_err) begin
                        mode_nx  = MODE_ERROR;
                        retry_nx = !st.no_retx;
                    end
                MODE_RX:
                    if (st.rx_ok)       mode_nx = MODE_IDLE;
                    else if (st.rx_err) begin
                        mode_nx  = MODE_ERROR;
                        retry_nx = 1'b0;
                    end
                MODE_ERROR:
                    if (st.frame_sync)
                        mode_nx = (retry_q && run_en) ? MODE_TX : MODE_IDLE;
                default: mode_nx = MODE_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= MODE_STANDBY;
            retry_q   <= 1'b0;
            boff_mode <= 1'b0;
        end else begin
            mode      <= mode_nx;
            retry_q   <= retry_nx;
            boff_mode <= boff_nx;
        end
    end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int unsigned QUIET_BITS = QUIET_BITS_DEF,
    parameter int unsigned BOFF_RUNS  = BOFF_RUNS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       rx_bit,
    input  logic       run_en,
    input  logic       wkpulse_en,
    input  logic       wkirq_en,
    input  logic       tx_req,
    input  logic       sof_pulse,
    input  logic       rx_ok,
    input  logic       rx_err,
    input  logic       tx_ok,
    input  logic       tx_err,
    input  logic       no_retx,
    input  logic       arb_lost,
    input  logic       bus_off,
    input  logic       frame_sync,
    output logic [2:0] mode_o,
    output logic       force_dom,
    output logic       wake_irq,
    output logic       run_rb,
    output logic       bt_enable
);
    engine_status_t st;
    mode_e          mode;
    logic           boff_mode;
    logic           quiet_done;
    logic           pulse_on;

    assign st = '{sof: sof_pulse, rx_ok: rx_ok, rx_err: rx_err, tx_ok: tx_ok,
                  tx_err: tx_err, no_retx: no_retx, arb_lost: arb_lost,
                  bus_off: bus_off, frame_sync: frame_sync};

    can_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .tick(bit_tick), .rx_bit(rx_bit),
        .run_en(run_en), .wkpulse_en(wkpulse_en), .tx_req(tx_req),
        .st(st), .quiet_done(quiet_done), .pulse_on(pulse_on),
        .mode(mode), .boff_mode(boff_mode)
    );

    can_quiet_counter #(.QUIET_BITS(QUIET_BITS), .BOFF_RUNS(BOFF_RUNS)) u_quiet (
        .clk(clk), .rst(rst), .clear(mode != MODE_RESYNC), .tick(bit_tick),
        .rx_bit(rx_bit), .long_mode(boff_mode), .done(quiet_done)
    );

    can_wake_ctrl u_wake (
        .clk(clk), .rst(rst), .mode(mode), .tick(bit_tick), .rx_bit(rx_bit),
        .irq_en(wkirq_en), .pulse_on(pulse_on), .force_dom(force_dom),
        .wake_irq(wake_irq)
    );

    assign mode_o    = mode;
    assign run_rb    = (mode != MODE_STANDBY);
    assign bt_enable = (mode != MODE_STANDBY);
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       rx_bit,
    input logic       run_en,
    input logic       wkpulse_en,
    input logic       wkirq_en,
    input logic       bus_off,
    input logic [2:0] mode_o,
    input logic       force_dom,
    input logic       wake_irq
);
    assert_reset_standby_R1: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == 3'd0 && !force_dom && !wake_irq));

    assert_irq_cause_R3: assert property (@(posedge clk) disable iff (rst)
        wake_irq |-> $past(mode_o == 3'd0 && bit_tick && !rx_bit && wkirq_en));

    assert_leave_standby_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 3'd0 && mode_o != 3'd0) |->
        (mode_o == ($past(wkpulse_en) ? 3'd1 : 3'd2)));

    assert_drive_only_wakeup_R5: assert property (@(posedge clk) disable iff (rst)
        force_dom |-> mode_o == 3'd1);

    assert_drive_ends_resync_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(force_dom) |-> mode_o == 3'd2);

    assert_resync_exit_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) == 3'd2 && mode_o == 3'd3) |-> $past(bit_tick && rx_bit));

    assert_stuck_low_R12: assert property (@(posedge clk) disable iff (rst)
        $past(mode_o == 3'd3 && !run_en && !rx_bit && !bus_off) |-> mode_o == 3'd3);
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
    .run_en(run_en), .wkpulse_en(wkpulse_en), .wkirq_en(wkirq_en),
    .bus_off(bus_off), .mode_o(mode_o), .force_dom(force_dom),
    .wake_irq(wake_irq)
);

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0, rx_bit = 1'b1, run_en = 1'b0, wkpulse_en = 1'b0;
    logic wkirq_en = 1'b0, tx_req = 1'b0, sof_pulse = 1'b0, rx_ok = 1'b0;
    logic rx_err = 1'b0, tx_ok = 1'b0, tx_err = 1'b0, no_retx = 1'b0;
    logic arb_lost = 1'b0, bus_off = 1'b0, frame_sync = 1'b0;
    logic [2:0] mode_o;
    logic force_dom, wake_irq, run_rb, bt_enable;

    int n_cmp = 0, n_bad = 0, cyc = 0, tick_div = 1;
    string phase = "R1";

    always #5 clk = ~clk;

    can_mode_seq dut_i (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .run_en(run_en), .wkpulse_en(wkpulse_en), .wkirq_en(wkirq_en),
        .tx_req(tx_req), .sof_pulse(sof_pulse), .rx_ok(rx_ok), .rx_err(rx_err),
        .tx_ok(tx_ok), .tx_err(tx_err), .no_retx(no_retx), .arb_lost(arb_lost),
        .bus_off(bus_off), .frame_sync(frame_sync), .mode_o(mode_o),
        .force_dom(force_dom), .wake_irq(wake_irq), .run_rb(run_rb),
        .bt_enable(bt_enable)
    );

    // behavioural reference
    int m_mode, m_bits, m_runs;
    bit m_on, m_irq, m_retry, m_boff;

    always @(posedge clk) begin
        int nx;
        bit fin;
        if (rst) begin
            m_mode = 0; m_bits = 0; m_runs = 0;
            m_on = 0; m_irq = 0; m_retry = 0; m_boff = 0;
        end else begin
            fin = (m_mode == 2) && bit_tick && rx_bit && (m_bits == 10) &&
                  (!m_boff || m_runs == 127);
            m_irq = (m_mode == 0) && bit_tick && !rx_bit && wkirq_en;
            nx = m_mode;
            if (m_mode >= 3 && bus_off) begin
                nx = 2; m_boff = 1;
            end else begin
                case (m_mode)
                    0: if (run_en) nx = wkpulse_en ? 1 : 2;
                    1: if (m_on && bit_tick) nx = 2;
                    2: if (!run_en && rx_bit) nx = 0;
                       else if (fin) begin nx = 3; m_boff = 0; end
                    3: if (!run_en) begin if (rx_bit) nx = 0; end
                       else if (tx_req) nx = 4;
                       else if (sof_pulse) nx = 5;
                    4: if (arb_lost) nx = 5;
                       else if (tx_ok) nx = 3;
                       else if (tx_err) begin nx = 6; m_retry = !no_retx; end
                    5: if (rx_ok) nx = 3;
                       else if (rx_err) begin nx = 6; m_retry = 0; end
                    6: if (frame_sync) nx = (m_retry && run_en) ? 4 : 3;
                    default: nx = 0;
                endcase
            end
            if (m_mode != 2) begin
                m_bits = 0; m_runs = 0;
            end else if (bit_tick) begin
                if (!rx_bit) m_bits = 0;
                else if (m_bits == 10) begin
                    m_bits = 0;
                    if (m_boff) m_runs++;
                end else m_bits++;
            end
            if (m_mode != 1) m_on = 0;
            else if (bit_tick) m_on = 1;
            m_mode = nx;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (mode_o != 3'(m_mode) || force_dom != (m_mode == 1 && m_on) ||
                wake_irq != m_irq || run_rb != (m_mode != 0) ||
                bt_enable != (m_mode != 0)) begin
                n_bad++;
                $display("FAIL %s cyc %0d: mode=%0d fd=%b irq=%b rb=%b bt=%b exp mode=%0d fd=%b irq=%b rb=%b",
                         phase, cyc, mode_o, force_dom, wake_irq, run_rb, bt_enable,
                         m_mode, (m_mode == 1 && m_on), m_irq, (m_mode != 0));
            end
        end
    end

    // bit strobe generator
    always @(negedge clk) begin
        cyc++;
        bit_tick <= ((cyc % tick_div) == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tx_req = 1;  1: sof_pulse = 1; 2: rx_ok = 1; 3: rx_err = 1;
            4: tx_ok = 1;   5: tx_err = 1;    6: arb_lost = 1; 7: bus_off = 1;
            default: frame_sync = 1;
        endcase
        @(negedge clk);
        {tx_req, sof_pulse, rx_ok, rx_err, tx_ok, tx_err, arb_lost, bus_off, frame_sync} = '0;
    endtask

    task automatic wait_mode(input int m, input int limit, output int took);
        took = 0;
        while (mode_o != 3'(m) && took < limit) begin
            @(negedge clk);
            took++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int took, hi;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        phase = "R1";
        check("R1 mode", mode_o, 0);
        check("R1 force_dom", force_dom, 0);
        check("R2 run_rb standby", run_rb, 0);

        // R3: wake interrupt
        phase = "R3";
        hi = 0;
        wkirq_en = 1; rx_bit = 0;
        repeat (3) begin @(negedge clk); hi += wake_irq; end
        rx_bit = 1; @(negedge clk);
        check("R3 irq seen", (hi > 0), 1);
        wkirq_en = 0; rx_bit = 0; hi = 0;
        repeat (4) begin @(negedge clk); hi += wake_irq; end
        rx_bit = 1;
        check("R3 irq masked", hi, 0);

        // R13: frame pulses ignored in standby
        phase = "R13";
        pulse(1); pulse(2); pulse(0); pulse(6);
        check("R13 standby kept", mode_o, 0);

        // R4 / R5: wake-up pulse with stretched strobe
        phase = "R5";
        tick_div = 4;
        wkpulse_en = 1; run_en = 1;
        @(negedge clk);
        check("R4 to wakeup", mode_o, 1);
        check("R2 run_rb active", run_rb, 1);
        hi = 0;
        while (mode_o == 3'd1) begin @(negedge clk); hi += force_dom; end
        check("R5 one bit time", hi, 4);
        check("R5 into resync", mode_o, 2);
        pulse(1);
        check("R13 resync ignores sof", mode_o, 2);

        // R6: dominant restarts the run
        phase = "R6";
        tick_div = 1;
        rx_bit = 0; @(negedge clk); rx_bit = 1;
        repeat (10) @(negedge clk);
        check("R6 not before 11", mode_o, 2);
        @(negedge clk);
        check("R6 idle after 11", mode_o, 3);

        // R8 / R9 / R10
        phase = "R9";
        pulse(0); check("R8 tx start", mode_o, 4);
        pulse(6); check("R9 arb lost", mode_o, 5);
        pulse(2); check("R9 rx ok", mode_o, 3);
        phase = "R8";
        @(negedge clk); tx_req = 1; sof_pulse = 1;
        @(negedge clk); tx_req = 0; sof_pulse = 0;
        check("R8 tx wins", mode_o, 4);
        pulse(4); check("R9 tx ok", mode_o, 3);
        phase = "R10";
        pulse(1); check("R8 rx start", mode_o, 5);
        pulse(3); check("R10 rx err", mode_o, 6);
        pulse(8); check("R10 rx err exit idle", mode_o, 3);
        pulse(0); no_retx = 0;
        pulse(5); check("R10 tx err", mode_o, 6);
        pulse(8); check("R10 retry", mode_o, 4);
        no_retx = 1;
        pulse(5); pulse(8);
        check("R10 no retry", mode_o, 3);
        no_retx = 0;

        // R11: run cleared mid-frame
        phase = "R11";
        pulse(0);
        run_en = 0;
        repeat (5) @(negedge clk);
        check("R11 frame kept", mode_o, 4);
        pulse(4);
        check("R11 idle first", mode_o, 3);
        @(negedge clk);
        check("R11 standby", mode_o, 0);

        // R12: stuck dominant
        phase = "R12";
        wkpulse_en = 0; run_en = 1;
        @(negedge clk);
        check("R4 direct resync", mode_o, 2);
        wait_mode(3, 50, took);
        check("R12 reach idle", mode_o, 3);
        rx_bit = 0; run_en = 0;
        repeat (10) @(negedge clk);
        check("R12 held idle", mode_o, 3);
        rx_bit = 1;
        @(negedge clk); @(negedge clk);
        check("R12 standby after release", mode_o, 0);

        // R7: bus-off recovery
        phase = "R7";
        run_en = 1;
        wait_mode(3, 50, took);
        pulse(7);
        check("R7 to resync", mode_o, 2);
        repeat (500) @(negedge clk);
        rx_bit = 0; @(negedge clk); rx_bit = 1;
        wait_mode(3, 5000, took);
        check("R7 recovered", mode_o, 3);
        check("R7 long wait", (took > 800), 1);
        pulse(7);
        pulse(1);
        check("R13 resync ignores sof after busoff", mode_o, 2);
        wait_mode(3, 5000, took);
        check("R7 second recovery", mode_o, 3);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule